// File: doc/BRIEF.md
# Fixed-Priority Nested Edge Interrupt Controller

This block gathers eleven interrupt sources for a small sequencer CPU and turns them into one vectored request. Five sources are external pins: a power-monitor hold input and four general interrupt pins. The other six are single-cycle internal events: two serial-port completions and four timer expiries. Each external pin passes through a two-flop synchroniser and an edge detector. The general pins can be set to trigger on either edge. The hold pin reacts only to a falling edge, and that edge also sets a sticky hold-status flag.

Pending flags are arbitrated by a fixed priority, and the winning source index is presented as `irq_vec` together with `irq_req`. When the CPU takes a vector, it pulses the matching `ack` bit. That pulse clears the pending flag and pushes the source onto an in-service stack of at most four levels. A pulse on `reti` pops the stack. A new request is presented only when it outranks the source now in service, so a higher-priority source can preempt a running handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req`, `irq_vec`, `pend_o`, `svc_depth` and `hold_status` are all zero, and every enable and polarity bit is cleared.
- R2: Source indices, from highest priority to lowest, are: 0 hold, 1 INT0 (`ext_pin[1]`), 2 INT1 (`ext_pin[2]`), 3 INT4 (`ext_pin[3]`), 4 INT5 (`ext_pin[4]`), 5 serial 0 (`int_evt[0]`), 6 serial 1 (`int_evt[1]`), 7 to 10 timers 0 to 3 (`int_evt[2..5]`). When requesting, `irq_vec` shows the lowest pending index.
- R3: Bit k of `cfg_rise` selects the active edge of `ext_pin[k+1]`. A value of 1 selects the rising edge and 0 selects the falling edge. The opposite edge sets nothing.
- R4: The hold input (`ext_pin[0]`) sets its pending flag only on a falling edge. A rising edge is ignored.
- R5: A falling edge on the hold input sets `hold_status` whatever the enable bit is. The flag stays set until `hold_clr` is pulsed, and a new edge in the same cycle wins over the clear.
- R6: An external source becomes pending only while its bit of `cfg_en` (loaded when `cfg_we` is high; bit i belongs to `ext_pin[i]`) is set. Internal events always become pending.
- R7: A pulse on `ack[i]` clears pending flag i. If that flag was set, the pulse also pushes source i onto the in-service stack and `svc_depth` rises by one. An ack of a source that is not pending leaves `svc_depth` unchanged.
- R8: While `svc_depth` is nonzero, a request is presented only for a pending source whose index is strictly lower than the top in-service index. `reti` pops one level, and `reti` at depth 0 has no effect.
- R9: `svc_depth` never exceeds 4. At depth 4, no request is presented.
- R10: An internal event sets its pending flag at the rising edge that samples it, and `irq_req` follows one edge later. A change on an external pin shows in `pend_o` on the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 5 | Asynchronous external pins; bit 0 is the hold input |
| int_evt | input | 6 | Internal event pulses: serial 0, serial 1, timers 0 to 3 |
| cfg_we | input | 1 | Loads `cfg_en` and `cfg_rise` |
| cfg_en | input | 5 | Per-external-pin enable |
| cfg_rise | input | 4 | Edge select for the general pins (1 = rising) |
| ack | input | 11 | Per-source acknowledge pulse when a vector is taken |
| reti | input | 1 | Return-from-interrupt strobe |
| hold_clr | input | 1 | Clears the sticky hold-status flag |
| irq_req | output | 1 | Registered vectored request |
| irq_vec | output | 4 | Registered index of the winning source |
| pend_o | output | 11 | Pending flags |
| svc_depth | output | 3 | Number of in-service levels |
| hold_status | output | 1 | Sticky hold-falling-edge flag |

## Verification
Every pair of the eleven sources is raised with the lower-priority source first. This shows that arbitration depends on rank and not on arrival order. Each pair is then serviced through ack and `reti`, which shows that the lower source stays blocked while the higher one is in service and is presented once the stack is popped. A ladder of four nested levels of rising priority checks preemption, the depth cap and pops at depth 0. Per-pin tests toggle each pin in both directions with its enable on and off, which separates the polarity selection, the hold pin's falling-only rule and the enable gating. Single-edge sampling checks the latency through the synchroniser.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  parameter int N_EXT  = 5;
  parameter int N_GEN  = N_EXT - 1;
  parameter int N_INTL = 6;
  parameter int N_SRC  = N_EXT + N_INTL;
  parameter int VEC_W  = $clog2(N_SRC);
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit #(
  parameter int SYNC_STAGES = 2,
  parameter bit FALL_ONLY   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic prev_q;
  logic cur;
  logic use_rise;

  assign cur      = sh_q[SYNC_STAGES-1];
  assign use_rise = FALL_ONLY ? 1'b0 : rise_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  assign edge_o = use_rise ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [CNT_W-1:0] depth_o,
  output logic [IDX_W-1:0] top_o
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] top_pos;
  logic             do_push;

  always_comb begin
    base    = (pop && depth_q != '0) ? depth_q - 1'b1 : depth_q;
    do_push = push && (base < CNT_W'(DEPTH));
    top_pos = depth_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[base[SLOT_W-1:0]] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= '0;
    else     depth_q <= base + CNT_W'(do_push);
  end

  assign depth_o = depth_q;
  assign top_o   = (depth_q == '0) ? '0 : slot_q[top_pos[SLOT_W-1:0]];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NEST_MAX    = 4,
  parameter int CNT_W       = $clog2(NEST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_INTL-1:0] int_evt,
  input  logic              cfg_we,
  input  logic [N_EXT-1:0]  cfg_en,
  input  logic [N_GEN-1:0]  cfg_rise,
  input  logic [N_SRC-1:0]  ack,
  input  logic              reti,
  input  logic              hold_clr,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [N_SRC-1:0]  pend_o,
  output logic [CNT_W-1:0]  svc_depth,
  output logic              hold_status
);
  logic [N_EXT-1:0] en_q;
  logic [N_GEN-1:0] rise_q;
  logic [N_EXT-1:0] ext_edge;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] take_v;
  logic             win_any, take_any, grant;
  vec_t             win_idx, take_idx, top_idx;
  logic [CNT_W-1:0] depth;
  logic             hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      rise_q <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_en;
      rise_q <= cfg_rise;
    end
  end

  irq_edge_unit #(.SYNC_STAGES(SYNC_STAGES), .FALL_ONLY(1'b1)) u_hold_edge (
    .clk(clk), .rst(rst), .pin(ext_pin[0]), .rise_sel(1'b0), .edge_o(ext_edge[0])
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen_pin
    irq_edge_unit #(.SYNC_STAGES(SYNC_STAGES), .FALL_ONLY(1'b0)) u_edge (
      .clk(clk), .rst(rst), .pin(ext_pin[g+1]), .rise_sel(rise_q[g]),
      .edge_o(ext_edge[g+1])
    );
  end

  assign set_v  = {int_evt, ext_edge & en_q};
  assign take_v = ack & pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~ack) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst)              hold_q <= 1'b0;
    else if (ext_edge[0]) hold_q <= 1'b1;
    else if (hold_clr)    hold_q <= 1'b0;
  end

  irq_prio_enc #(.N(N_SRC), .IDX_W(VEC_W)) u_win (
    .req(pend_q), .any(win_any), .idx(win_idx)
  );

  irq_prio_enc #(.N(N_SRC), .IDX_W(VEC_W)) u_take (
    .req(take_v), .any(take_any), .idx(take_idx)
  );

  irq_nest_stack #(.DEPTH(NEST_MAX), .IDX_W(VEC_W), .CNT_W(CNT_W)) u_stack (
    .clk(clk), .rst(rst), .push(take_any), .push_idx(take_idx), .pop(reti),
    .depth_o(depth), .top_o(top_idx)
  );

  assign grant = win_any &&
                 ((depth == '0) ||
                  ((depth < CNT_W'(NEST_MAX)) && (win_idx < top_idx)));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= grant;
      irq_vec <= grant ? win_idx : '0;
    end
  end

  assign pend_o      = pend_q;
  assign svc_depth   = depth;
  assign hold_status = hold_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NEST_MAX = 4,
  parameter int CNT_W    = $clog2(NEST_MAX + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [N_SRC-1:0] pend_o,
  input logic [CNT_W-1:0] svc_depth,
  input logic             hold_status,
  input logic             hold_clr,
  input logic [N_SRC-1:0] ack,
  input logic             reti,
  input logic [N_EXT-1:0] en_q
);
  localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

  p_win_pend_r2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((($past(pend_o) >> irq_vec) & ONE) != '0));

  p_win_top_r2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (($past(pend_o) & ((ONE << irq_vec) - ONE)) == '0));

  for (genvar k = 0; k < N_EXT; k++) begin : g_en
    p_en_gate_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_o[k]) |-> $past(en_q[k]));
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (hold_status && !hold_clr) |=> hold_status);

  p_push_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (svc_depth > $past(svc_depth)) |-> ($past(ack) != '0));

  p_reti_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (svc_depth == '0 && reti && ack == '0) |=> (svc_depth == '0));

  p_depth_cap_r9: assert property (@(posedge clk) disable iff (rst)
    svc_depth <= CNT_W'(NEST_MAX));

  p_full_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (svc_depth == CNT_W'(NEST_MAX)) |=> !irq_req);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NEST_MAX(NEST_MAX), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec), .pend_o(pend_o),
  .svc_depth(svc_depth), .hold_status(hold_status), .hold_clr(hold_clr),
  .ack(ack), .reti(reti), .en_q(en_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ext_pin = 5'b00001;
  logic [5:0]  int_evt = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_en = '0;
  logic [3:0]  cfg_rise = '0;
  logic [10:0] ack = '0;
  logic        reti = 1'b0;
  logic        hold_clr = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [10:0] pend_o;
  logic [2:0]  svc_depth;
  logic        hold_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_evt(int_evt), .cfg_we(cfg_we),
    .cfg_en(cfg_en), .cfg_rise(cfg_rise), .ack(ack), .reti(reti),
    .hold_clr(hold_clr), .irq_req(irq_req), .irq_vec(irq_vec), .pend_o(pend_o),
    .svc_depth(svc_depth), .hold_status(hold_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [4:0] en, input logic [3:0] rise);
    cfg_en = en; cfg_rise = rise; cfg_we = 1'b1;
    wt(1);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input int idx);
    if (idx == 0) begin
      ext_pin[0] = 1'b0; wt(3); ext_pin[0] = 1'b1; wt(3);
    end else if (idx < 5) begin
      ext_pin[idx] = 1'b1; wt(3); ext_pin[idx] = 1'b0; wt(3);
    end else begin
      int_evt[idx-5] = 1'b1; wt(1); int_evt[idx-5] = 1'b0;
    end
  endtask

  task automatic do_ack(input int idx);
    ack = 11'(1) << idx;
    wt(1);
    ack = '0;
  endtask

  task automatic do_reti();
    reti = 1'b1; wt(1); reti = 1'b0;
  endtask

  initial begin
    wt(4);
    rst = 1'b0;
    wt(1);
    // R1 reset state
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 irq_vec", int'(irq_vec), 0);
    chk("R1 pend_o", int'(pend_o), 0);
    chk("R1 svc_depth", int'(svc_depth), 0);
    chk("R1 hold_status", int'(hold_status), 0);

    // R6 disabled pins do nothing
    fire(2); wt(2);
    chk("R6 disabled pin pend", int'(pend_o), 0);

    cfg(5'h1F, 4'hF);

    // R10 internal latency
    int_evt[3] = 1'b1; wt(1); int_evt[3] = 1'b0;
    chk("R10 internal pend", int'(pend_o[8]), 1);
    chk("R10 internal req not yet", int'(irq_req), 0);
    wt(1);
    chk("R10 internal req", int'(irq_req), 1);
    chk("R10 internal vec", int'(irq_vec), 8);
    do_ack(8); wt(1); do_reti(); wt(1);

    // R10 external latency
    ext_pin[3] = 1'b1; wt(2);
    chk("R10 ext pend before", int'(pend_o[3]), 0);
    wt(1);
    chk("R10 ext pend after", int'(pend_o[3]), 1);
    ext_pin[3] = 1'b0; wt(3);
    do_ack(3); wt(1); do_reti(); wt(2);

    // R2 and R8: every pair, lower priority raised first
    for (int i = 0; i < 11; i++) begin
      for (int j = i + 1; j < 11; j++) begin
        fire(j); fire(i); wt(2);
        chk("R2 pair req", int'(irq_req), 1);
        chk("R2 pair vec", int'(irq_vec), i);
        do_ack(i); wt(1);
        chk("R7 pair depth", int'(svc_depth), 1);
        chk("R8 lower blocked", int'(irq_req), 0);
        do_reti(); wt(1);
        chk("R8 after pop vec", int'(irq_vec), j);
        chk("R8 after pop req", int'(irq_req), 1);
        do_ack(j); wt(1); do_reti(); wt(1);
        chk("R7 pair cleared", int'(pend_o), 0);
      end
    end

    // R5 sticky hold flag
    chk("R5 hold set", int'(hold_status), 1);
    hold_clr = 1'b1; wt(1); hold_clr = 1'b0;
    chk("R5 hold cleared", int'(hold_status), 0);

    // R4 hold rising ignored, falling taken
    ext_pin[0] = 1'b0; wt(4);
    chk("R4 hold fall pend", int'(pend_o[0]), 1);
    do_ack(0); wt(1); do_reti(); wt(1);
    ext_pin[0] = 1'b1; wt(4);
    chk("R4 hold rise ignored", int'(pend_o[0]), 0);

    // R5 and R6 hold disabled still flags status
    hold_clr = 1'b1; wt(1); hold_clr = 1'b0;
    cfg(5'h1E, 4'hF);
    fire(0);
    chk("R6 hold disabled pend", int'(pend_o[0]), 0);
    chk("R5 hold status while disabled", int'(hold_status), 1);

    // R3 falling polarity on INT0
    cfg(5'h1F, 4'hE);
    ext_pin[1] = 1'b1; wt(4);
    chk("R3 rise ignored in fall mode", int'(pend_o[1]), 0);
    ext_pin[1] = 1'b0; wt(4);
    chk("R3 fall taken", int'(pend_o[1]), 1);
    do_ack(1); wt(1); do_reti(); wt(1);
    cfg(5'h1F, 4'hF);

    // R7 ack of non-pending source
    do_ack(3); wt(1);
    chk("R7 ack non-pending depth", int'(svc_depth), 0);

    // R8 preemption ladder and R9 depth cap
    fire(10); wt(1); do_ack(10); wt(1);
    fire(7); wt(1);
    chk("R8 preempt req", int'(irq_req), 1);
    chk("R8 preempt vec", int'(irq_vec), 7);
    do_ack(7);
    fire(5); wt(1); do_ack(5);
    fire(2); wt(1); do_ack(2); wt(1);
    chk("R9 depth four", int'(svc_depth), 4);
    fire(0); wt(2);
    chk("R9 full no req", int'(irq_req), 0);
    chk("R9 full pend kept", int'(pend_o[0]), 1);
    do_reti(); wt(1);
    chk("R8 pop exposes req", int'(irq_req), 1);
    chk("R8 pop exposes vec", int'(irq_vec), 0);
    do_ack(0); wt(1);
    chk("R9 depth back to four", int'(svc_depth), 4);
    do_ack(6); wt(1);
    for (int k = 0; k < 5; k++) do_reti();
    wt(1);
    chk("R8 reti at empty", int'(svc_depth), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule